// File: doc/BRIEF.md
# Serial Column Mixer with Word Writeback

This block is the mixing stage of a byte-serial block-cipher round. Substituted state bytes arrive one per cycle, and four accepted bytes form one column. Each byte is multiplied in GF(2^8) by the matching column of the circulant matrix [02 03 01 01] and folded into a 32-bit accumulator. The accumulator starts again from zero at the first byte of every column. When the fourth byte is accepted, the whole mixed column is XORed with a 32-bit round-key word and presented at once, with a one-cycle write strobe, so that the state store can take the column as a single word write. A 16-cycle round therefore produces four word writes, one on every fourth accepted byte.

In the final round the mixing is bypassed. Each incoming byte is XORed with one byte of the key word, chosen by its position in the column, and the result leaves as one ciphertext byte per cycle. Gaps in the input stream are allowed: a cycle without valid neither advances the column position nor changes any output word.

Top module: `serial_mixcol_wb`

## Requirements
- R1: After reset, wr_stb and ct_vld are low, wr_word and ct_byte are zero, and the next accepted byte is position 0 of a column.
- R2: The accepted byte at position k (k counts accepted bytes modulo 4 since reset, in both modes) is scaled into result row r by the coefficient at index (k - r) mod 4 of the list {02, 03, 01, 01}. Row 0 sits in wr_word[31:24] and row 3 in wr_word[7:0].
- R3: When the byte at position 3 is accepted with last_rnd low, wr_stb is high for exactly the following cycle, and wr_word then holds the mixed column XOR rkey_word, where rkey_word is the value sampled together with that byte. wr_stb is low after every other cycle.
- R4: Each column's result depends only on its own four bytes, because the accumulator is cleared when the position-0 byte is accepted.
- R5: A cycle with in_vld low does not accumulate, does not advance the position, and is followed by wr_stb and ct_vld both low.
- R6: When a byte is accepted with last_rnd high, ct_vld is high in the following cycle and ct_byte equals in_byte XOR rkey_word[31-8k -: 8], where k is the byte's position. No word strobe follows that byte.
- R7: wr_word changes only on the edge that raises wr_stb, and it holds its value otherwise.
- R8: Multiply-by-02 is a left shift, XORed with 0x1B when the shifted-out bit was 1. With a zero key, the column db 13 53 45 yields wr_word 8e4da1bc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | An input byte is offered this cycle |
| in_byte | input | 8 | Substituted state byte |
| last_rnd | input | 1 | Final-round mode: bypass mixing, emit ciphertext bytes |
| rkey_word | input | 32 | Round-key word, byte 0 in bits 31:24 |
| wr_stb | output | 1 | One-cycle strobe: wr_word is a finished column |
| wr_word | output | 32 | Key-added mixed column for writeback |
| ct_vld | output | 1 | ct_byte is valid (final round) |
| ct_byte | output | 8 | Ciphertext byte (final round) |

## Verification
Every result is due one clock after the edge that accepts its byte. The word strobe follows the fourth byte of a column, and the ciphertext byte follows each final-round byte. The bench drives inputs on the falling edge and samples the outputs on the next falling edge, which is exactly one register stage later. It checks every strobe cycle and every non-strobe cycle, and it checks idle gaps for an unchanged word.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned BW    = 8;
  localparam int unsigned POS_W = $clog2(LANES);
  localparam int unsigned WORD_W = LANES * BW;

  typedef enum logic [1:0] {CF_ONE = 2'd0, CF_TWO = 2'd1, CF_THREE = 2'd2} coef_e;

  function automatic logic [BW-1:0] gf_dbl(input logic [BW-1:0] a, input logic [BW-1:0] poly);
    return {a[BW-2:0], 1'b0} ^ (a[BW-1] ? poly : '0);
  endfunction

  function automatic logic [BW-1:0] gf_scale(input logic [BW-1:0] a, input coef_e c,
                                             input logic [BW-1:0] poly);
    logic [BW-1:0] d;
    d = gf_dbl(a, poly);
    case (c)
      CF_TWO:   return d;
      CF_THREE: return d ^ a;
      default:  return a;
    endcase
  endfunction

  // circulant row pattern {02,03,01,01}, indexed by (col - row) mod LANES
  function automatic coef_e coef_at(input logic [POS_W-1:0] col, input logic [POS_W-1:0] row);
    logic [POS_W-1:0] idx;
    idx = col - row;
    case (idx)
      2'd0:    return CF_TWO;
      2'd1:    return CF_THREE;
      default: return CF_ONE;
    endcase
  endfunction
endpackage

// File: rtl/smc_rst_sync.sv
module smc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/smc_pos_ctr.sv
module smc_pos_ctr
  import smc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [POS_W-1:0] pos,
  output logic             at_first,
  output logic             at_last
);
  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (adv) pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos      = pos_q;
  assign at_first = (pos_q == '0);
  assign at_last  = (pos_q == POS_W'(LANES - 1));
endmodule

// File: rtl/smc_col_term.sv
module smc_col_term
  import smc_pkg::*;
#(
  parameter logic [7:0] POLY = 8'h1B
) (
  input  logic [BW-1:0]     byte_in,
  input  logic [POS_W-1:0]  pos,
  output logic [WORD_W-1:0] term
);
  for (genvar r = 0; r < LANES; r++) begin : g_row
    localparam logic [POS_W-1:0] ROW = POS_W'(r);
    assign term[(LANES-1-r)*BW +: BW] = gf_scale(byte_in, coef_at(pos, ROW), POLY);
  end
endmodule

// File: rtl/smc_last_out.sv
module smc_last_out
  import smc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BW-1:0]     byte_in,
  input  logic [WORD_W-1:0] key_word,
  input  logic [POS_W-1:0]  pos,
  output logic              ct_vld,
  output logic [BW-1:0]     ct_byte
);
  logic [BW-1:0] key_b, byte_q, byte_d;
  logic          vld_q, vld_d;

  always_comb begin
    key_b = '0;
    for (int i = 0; i < LANES; i++) begin
      if (pos == POS_W'(i)) key_b = key_word[(LANES-1-i)*BW +: BW];
    end
  end

  always_comb begin
    vld_d  = take;
    byte_d = byte_q;
    if (take) byte_d = byte_in ^ key_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      vld_q  <= vld_d;
      byte_q <= byte_d;
    end
  end

  assign ct_vld  = vld_q;
  assign ct_byte = byte_q;
endmodule

// File: rtl/serial_mixcol_wb.sv
module serial_mixcol_wb
  import smc_pkg::*;
#(
  parameter logic [7:0] POLY = 8'h1B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_vld,
  input  logic [7:0]  in_byte,
  input  logic        last_rnd,
  input  logic [31:0] rkey_word,
  output logic        wr_stb,
  output logic [31:0] wr_word,
  output logic        ct_vld,
  output logic [7:0]  ct_byte
);
  logic              rst_i_n;
  logic [POS_W-1:0]  pos;
  logic              at_first, at_last;
  logic              mix_take, fin_take;
  logic [WORD_W-1:0] term, acc_q, acc_d, word_q, word_d, col_sum;
  logic              stb_q, stb_d;

  smc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  smc_pos_ctr u_pos (
    .clk(clk), .rst_n(rst_i_n), .adv(in_vld),
    .pos(pos), .at_first(at_first), .at_last(at_last)
  );

  smc_col_term #(.POLY(POLY)) u_term (
    .byte_in(in_byte), .pos(pos), .term(term)
  );

  smc_last_out u_fin (
    .clk(clk), .rst_n(rst_i_n), .take(fin_take), .byte_in(in_byte),
    .key_word(rkey_word), .pos(pos), .ct_vld(ct_vld), .ct_byte(ct_byte)
  );

  assign mix_take = in_vld & ~last_rnd;
  assign fin_take = in_vld & last_rnd;
  assign col_sum  = (at_first ? '0 : acc_q) ^ term;

  always_comb begin
    acc_d  = acc_q;
    word_d = word_q;
    stb_d  = mix_take & at_last;
    if (mix_take)         acc_d  = col_sum;
    if (mix_take && at_last) word_d = col_sum ^ rkey_word;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      acc_q  <= '0;
      word_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      word_q <= word_d;
      stb_q  <= stb_d;
    end
  end

  assign wr_stb  = stb_q;
  assign wr_word = word_q;
endmodule

// File: rtl/smc_chk.sv
module smc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_vld,
  input logic        last_rnd,
  input logic        wr_stb,
  input logic [31:0] wr_word,
  input logic        ct_vld
);
  logic [1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seen_q <= '0;
    else if (in_vld) seen_q <= seen_q + 2'd1;
  end

  a_r3_strobe_on_fourth: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !last_rnd && seen_q == 2'd3) |=> wr_stb);

  a_r3_no_early_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && seen_q != 2'd3) |=> !wr_stb);

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!wr_stb && !ct_vld));

  a_r6_final_byte_out: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && last_rnd) |=> (ct_vld && !wr_stb));

  a_r6_mix_no_ct: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !last_rnd) |=> !ct_vld);

  a_r7_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> $stable(wr_word));
endmodule

bind serial_mixcol_wb smc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .last_rnd(last_rnd),
  .wr_stb(wr_stb), .wr_word(wr_word), .ct_vld(ct_vld)
);

// File: tb/serial_mixcol_wb_tb_top.sv
module serial_mixcol_wb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [7:0]  in_byte;
  logic        last_rnd;
  logic [31:0] rkey_word;
  logic        wr_stb;
  logic [31:0] wr_word;
  logic        ct_vld;
  logic [7:0]  ct_byte;

  int total = 0;
  int bad   = 0;
  int bp    = 0;
  logic [31:0] held;

  always #5 clk = ~clk;

  serial_mixcol_wb dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte),
    .last_rnd(last_rnd), .rkey_word(rkey_word), .wr_stb(wr_stb),
    .wr_word(wr_word), .ct_vld(ct_vld), .ct_byte(ct_byte)
  );

  function automatic logic [7:0] m2(input logic [7:0] a);
    logic [8:0] w;
    w = {a, 1'b0};
    if (w[8]) w = w ^ 9'h11B;
    return w[7:0];
  endfunction

  function automatic logic [31:0] mix_ref(input logic [7:0] a0, input logic [7:0] a1,
                                          input logic [7:0] a2, input logic [7:0] a3);
    logic [7:0] o0, o1, o2, o3;
    o0 = m2(a0) ^ m2(a1) ^ a1 ^ a2 ^ a3;
    o1 = a0 ^ m2(a1) ^ m2(a2) ^ a2 ^ a3;
    o2 = a0 ^ a1 ^ m2(a2) ^ m2(a3) ^ a3;
    o3 = m2(a0) ^ a0 ^ a1 ^ a2 ^ m2(a3);
    return {o0, o1, o2, o3};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] b, input logic lr, input logic [31:0] k);
    in_vld = v; in_byte = b; last_rnd = lr; rkey_word = k;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic idle_step();
    held = wr_word;
    step(1'b0, 8'h00, 1'b0, 32'h0);
    chk("R5 idle no strobe", {31'd0, wr_stb}, 32'd0);
    chk("R5 idle no ct_vld", {31'd0, ct_vld}, 32'd0);
    chk("R7 word held", wr_word, held);
  endtask

  // sends four bytes; gaps bit i inserts an idle cycle before byte i
  task automatic send_col(input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] a2,
                          input logic [7:0] a3, input logic [31:0] k, input logic lr,
                          input logic [3:0] gaps, input string tag);
    logic [7:0] bs [4];
    logic [31:0] exp;
    bs[0] = a0; bs[1] = a1; bs[2] = a2; bs[3] = a3;
    exp = mix_ref(a0, a1, a2, a3) ^ k;
    for (int i = 0; i < 4; i++) begin
      if (gaps[i]) idle_step();
      held = wr_word;
      step(1'b1, bs[i], lr, k);
      if (lr) begin
        chk({tag, " R6 ct_vld"}, {31'd0, ct_vld}, 32'd1);
        chk({tag, " R6 ct_byte"}, {24'd0, ct_byte}, {24'd0, bs[i] ^ k[31-8*bp -: 8]});
        chk({tag, " R6 no strobe"}, {31'd0, wr_stb}, 32'd0);
      end else if (bp == 3) begin
        chk({tag, " R3 strobe"}, {31'd0, wr_stb}, 32'd1);
        chk({tag, " R3 R2 R4 word"}, wr_word, exp);
      end else begin
        chk({tag, " R3 no early strobe"}, {31'd0, wr_stb}, 32'd0);
        chk({tag, " R7 word held"}, wr_word, held);
      end
      bp = (bp + 1) % 4;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_vld = 1'b0; in_byte = '0; last_rnd = 1'b0; rkey_word = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset wr_stb", {31'd0, wr_stb}, 32'd0);
    chk("R1 reset ct_vld", {31'd0, ct_vld}, 32'd0);
    chk("R1 reset wr_word", wr_word, 32'd0);
    chk("R1 reset ct_byte", {24'd0, ct_byte}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 known column, zero key
    send_col(8'hdb, 8'h13, 8'h53, 8'h45, 32'h0, 1'b0, 4'b0000, "R8 vec");
    chk("R8 vector", wr_word, 32'h8e4da1bc);
    idle_step();
    // R2 single nonzero byte at position 2 -> coefficients 01 03 02 01
    send_col(8'h00, 8'h00, 8'h01, 8'h00, 32'h0, 1'b0, 4'b0000, "R2 unit");
    chk("R2 unit pos2", wr_word, 32'h01030201);
    // R4 back-to-back columns, keyed
    send_col(8'hf2, 8'h0a, 8'h22, 8'h5c, 32'ha5a5a5a5, 1'b0, 4'b0000, "R4 a");
    send_col(8'h01, 8'h01, 8'h01, 8'h01, 32'h12345678, 1'b0, 4'b0000, "R4 b");
    chk("R4 identity column", wr_word, 32'h01010101 ^ 32'h12345678);
    // R5 gaps between every byte
    send_col(8'hc6, 8'hc6, 8'hc6, 8'hc6, 32'hdeadbeef, 1'b0, 4'b1111, "R5 gaps");
    idle_step();
    idle_step();
    // R6 final-round bytes
    send_col(8'h10, 8'h20, 8'h30, 8'h40, 32'h00112233, 1'b1, 4'b0100, "R6 dir");

    for (int n = 0; n < 400; n++) begin
      send_col(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), $urandom,
               1'(($urandom % 4) == 0), 4'($urandom & ($urandom)), "rnd");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule